// File: doc/BRIEF.md
# Video Gain and Clamp Control Loop

This block closes the digital side of the gain and clamp loops for one digitized composite or luma video channel. Every valid sample it looks at the 9-bit converter output together with three timing flags: a window around the horizontal sync tip, a window on the back porch for clamping, and a vertical blanking flag. From the sync tip level and from white-peak overshoots it integrates gain corrections into an 18-bit accumulator. The top nine accumulator bits form the actual gain, which spans roughly -6 dB to +6 dB with mid-scale at 0 dB. A separate published gain code drives the gain DAC. It follows the actual gain only when the two have drifted apart by more than a programmable threshold, so small integration noise never reaches the amplifier.

The sample stream arrives on a valid/ready interface. `s_ready` is held high at all times: the loop consumes one sample per cycle whenever `s_valid` is high and never applies back-pressure, and cycles with `s_valid` low have no effect on the loop state. The clamp outputs are plain per-cycle requests, and the configuration inputs are plain static levels.

Top module: `video_gain_loop`

## Requirements
- R1: After reset, `gain_code` is 256 (accumulator at mid-scale, 0 dB), `clamp_up` and `clamp_dn` are 0, and `s_ready` is 1.
- R2: A valid sample taken inside the clamp window while blanking is low sets, one cycle later, `clamp_up` when the sample is below the reference and `clamp_dn` when it is above. The reference is 120 with `cfg_chroma`=0 and 256 with `cfg_chroma`=1. In every other case, including outside the window and during blanking, both outputs are 0 that cycle.
- R3: A valid sample above 254 while blanking is low is a white peak. It lowers the accumulator by one unit at half the sample rate, on the 2nd, 4th, 6th, ... valid sample counted since reset.
- R4: With `cfg_wp_off`=1, samples above 254 have no effect on the gain.
- R5: Inside the sync window, a valid sample below the sync-tip target of 1 (code 0) lowers the accumulator by one unit, at the same half-rate pace as R3.
- R6: A line ends on the first valid sample with the sync window low after a valid sample that had it high. If every window sample of that line was above 1 and no white peak has been seen in the current field, the accumulator rises by one unit.
- R7: Once a white peak has been seen in a field, per-line rises stop. Instead, the accumulator rises by one unit at the end of blanking, the first valid sample with blanking low after one with it high, provided some line in that field ended with its tip above 1. Both field flags then clear.
- R8: While blanking is high, or while `cfg_hold`=1, the accumulator does not change.
- R9: The published gain (`gain_code` when `cfg_fixed`=0) is reloaded from the actual gain, the top 9 accumulator bits, one cycle after their absolute difference exceeds `cfg_thresh`. Otherwise it stays put.
- R10: With `cfg_fixed`=1, `gain_code` equals `cfg_static_gain` and the accumulator is held.
- R11: The accumulator saturates at 0 and at its maximum and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Always 1; the block never stalls the stream |
| s_sample | input | 9 | Converter sample |
| hsync_win | input | 1 | Sync-tip measurement window |
| clamp_win | input | 1 | Back-porch clamp window |
| vblank | input | 1 | Vertical blanking flag |
| cfg_hold | input | 1 | Freeze gain integration |
| cfg_fixed | input | 1 | Drive static gain to the DAC |
| cfg_static_gain | input | 9 | Static gain code |
| cfg_wp_off | input | 1 | Disable white-peak limiting |
| cfg_thresh | input | 3 | Publish threshold |
| cfg_chroma | input | 1 | Select chroma clamp reference |
| gain_code | output | 9 | Gain code to the DAC |
| clamp_up | output | 1 | Request clamp level raise |
| clamp_dn | output | 1 | Request clamp level lowering |

## Verification
The bound checker watches, on every cycle, that the accumulator stays still while frozen and never moves by more than the largest legal step in either direction, which rules out wrapping. It also checks that the published gain holds whenever the drift is within the threshold, and that the clamp requests are exclusive and silent outside a live clamp window. The step sizes themselves can only be shown by the bench scenarios: the half-rate decay for peaks and low tips, the per-line rise, and its hand-over to a per-field rise after a peak. The same holds for the exact publish points under a threshold, the fixed-gain override and saturation at both ends. Saturation is reached through a second instance with a narrow accumulator.

// File: rtl/vgl_pkg.sv
package vgl_pkg;
  localparam int WP_LIMIT     = 254;  // white-peak limit code
  localparam int SB_TARGET    = 1;    // sync-tip target code
  localparam int CLAMP_LUMA   = 120;
  localparam int CLAMP_CHROMA = 256;

  typedef struct packed {
    logic dec;        // half-rate decrement
    logic inc_line;   // per-line increment
    logic inc_field;  // per-field increment
  } gain_evt_t;
endpackage

// File: rtl/vgl_measure.sv
module vgl_measure
  import vgl_pkg::*;
#(
  parameter int SAMPLE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                hs_win,
  input  logic                vb,
  input  logic                wp_off,
  input  logic                freeze,
  output gain_evt_t           evt
);
  localparam logic [SAMPLE_W-1:0] PEAK_LVL = SAMPLE_W'(WP_LIMIT);
  localparam logic [SAMPLE_W-1:0] TIP_LVL  = SAMPLE_W'(SB_TARGET);

  logic                phase_q;
  logic                hs_q, vb_q;
  logic [SAMPLE_W-1:0] win_min_q;
  logic                peak_seen_q, high_seen_q;

  logic live, peak, tip_low, line_end, field_end, tip_high;

  always_comb begin
    live      = valid && !vb;
    peak      = live && !wp_off && (sample > PEAK_LVL);
    tip_low   = live && hs_win && (sample < TIP_LVL);
    line_end  = live && hs_q && !hs_win;
    field_end = valid && vb_q && !vb;
    tip_high  = win_min_q > TIP_LVL;

    evt.dec       = phase_q && (peak || tip_low) && !freeze;
    evt.inc_line  = line_end && tip_high && !peak_seen_q && !freeze;
    evt.inc_field = field_end && peak_seen_q && high_seen_q && !freeze;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= 1'b0;
      hs_q        <= 1'b0;
      vb_q        <= 1'b0;
      win_min_q   <= '1;
      peak_seen_q <= 1'b0;
      high_seen_q <= 1'b0;
    end else if (valid) begin
      phase_q <= !phase_q;
      hs_q    <= hs_win;
      vb_q    <= vb;
      if (field_end) begin
        peak_seen_q <= 1'b0;
        high_seen_q <= 1'b0;
      end else begin
        if (peak)                  peak_seen_q <= 1'b1;
        if (line_end && tip_high)  high_seen_q <= 1'b1;
      end
      if (line_end)
        win_min_q <= '1;
      else if (live && hs_win && (sample < win_min_q))
        win_min_q <= sample;
    end
  end
endmodule

// File: rtl/vgl_accum.sv
module vgl_accum
  import vgl_pkg::*;
#(
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gain_evt_t        evt,
  output logic [ACC_W-1:0] acc
);
  localparam logic [ACC_W-1:0] MID   = ACC_W'(1) << (ACC_W - 1);
  localparam logic [ACC_W+1:0] MAXV  = {2'b00, {ACC_W{1'b1}}};

  logic [1:0]       up;
  logic [ACC_W+1:0] t_up, t_dn;
  logic [ACC_W-1:0] nxt;

  always_comb begin
    up   = 2'(evt.inc_line) + 2'(evt.inc_field);
    t_up = {2'b00, acc} + {{ACC_W{1'b0}}, up};
    if (evt.dec && t_up != '0) t_dn = t_up - 1'b1;
    else                       t_dn = t_up;
    if (t_dn > MAXV) nxt = {ACC_W{1'b1}};
    else             nxt = t_dn[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= MID;
    else        acc <= nxt;
  end
endmodule

// File: rtl/vgl_publish.sv
module vgl_publish #(
  parameter int GAIN_W = 9,
  parameter int THR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAIN_W-1:0] actual,
  input  logic [THR_W-1:0]  thresh,
  output logic [GAIN_W-1:0] frozen
);
  localparam logic [GAIN_W-1:0] MID = GAIN_W'(1) << (GAIN_W - 1);

  logic [GAIN_W-1:0] drift;

  always_comb begin
    if (actual > frozen) drift = actual - frozen;
    else                 drift = frozen - actual;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      frozen <= MID;
    else if (drift > {{(GAIN_W-THR_W){1'b0}}, thresh})
      frozen <= actual;
  end
endmodule

// File: rtl/vgl_clamp.sv
module vgl_clamp
  import vgl_pkg::*;
#(
  parameter int SAMPLE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                cl_win,
  input  logic                vb,
  input  logic                chroma,
  output logic                up,
  output logic                dn
);
  localparam logic [SAMPLE_W-1:0] REF_Y = SAMPLE_W'(CLAMP_LUMA);
  localparam logic [SAMPLE_W-1:0] REF_C = SAMPLE_W'(CLAMP_CHROMA);

  logic [SAMPLE_W-1:0] ref_lvl;
  logic                act;

  always_comb begin
    ref_lvl = chroma ? REF_C : REF_Y;
    act     = valid && cl_win && !vb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= act && (sample < ref_lvl);
      dn <= act && (sample > ref_lvl);
    end
  end
endmodule

// File: rtl/video_gain_loop.sv
module video_gain_loop
  import vgl_pkg::*;
#(
  parameter int SAMPLE_W = 9,
  parameter int GAIN_W   = 9,
  parameter int ACC_W    = 18,
  parameter int THR_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_sample,
  input  logic                hsync_win,
  input  logic                clamp_win,
  input  logic                vblank,
  input  logic                cfg_hold,
  input  logic                cfg_fixed,
  input  logic [GAIN_W-1:0]   cfg_static_gain,
  input  logic                cfg_wp_off,
  input  logic [THR_W-1:0]    cfg_thresh,
  input  logic                cfg_chroma,
  output logic [GAIN_W-1:0]   gain_code,
  output logic                clamp_up,
  output logic                clamp_dn
);
  gain_evt_t         evt;
  logic [ACC_W-1:0]  acc_q;
  logic [GAIN_W-1:0] actual;
  logic [GAIN_W-1:0] fgv_q;

  assign s_ready = 1'b1;
  assign actual  = acc_q[ACC_W-1 -: GAIN_W];

  vgl_measure #(.SAMPLE_W(SAMPLE_W)) meas_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (s_valid),
    .sample (s_sample),
    .hs_win (hsync_win),
    .vb     (vblank),
    .wp_off (cfg_wp_off),
    .freeze (cfg_hold | cfg_fixed),
    .evt    (evt)
  );

  vgl_accum #(.ACC_W(ACC_W)) acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .acc   (acc_q)
  );

  vgl_publish #(.GAIN_W(GAIN_W), .THR_W(THR_W)) pub_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .actual (actual),
    .thresh (cfg_thresh),
    .frozen (fgv_q)
  );

  vgl_clamp #(.SAMPLE_W(SAMPLE_W)) clamp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (s_valid),
    .sample (s_sample),
    .cl_win (clamp_win),
    .vb     (vblank),
    .chroma (cfg_chroma),
    .up     (clamp_up),
    .dn     (clamp_dn)
  );

  assign gain_code = cfg_fixed ? cfg_static_gain : fgv_q;
endmodule

// File: rtl/vgl_checker.sv
module vgl_checker #(
  parameter int GAIN_W = 9,
  parameter int ACC_W  = 18,
  parameter int THR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              clamp_win,
  input logic              vblank,
  input logic              cfg_hold,
  input logic              cfg_fixed,
  input logic [THR_W-1:0]  cfg_thresh,
  input logic [ACC_W-1:0]  acc_q,
  input logic [GAIN_W-1:0] fgv_q,
  input logic              clamp_up,
  input logic              clamp_dn
);
  logic [ACC_W+1:0]  acc_x, prev_x;
  logic [ACC_W-1:0]  prev_q;
  logic [GAIN_W-1:0] act, drift;

  assign act   = acc_q[ACC_W-1 -: GAIN_W];
  assign drift = (act > fgv_q) ? act - fgv_q : fgv_q - act;
  assign acc_x  = {2'b00, acc_q};
  assign prev_x = {2'b00, prev_q};

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= ACC_W'(1) << (ACC_W - 1);
    else        prev_q <= acc_q;
  end

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && (vblank || cfg_hold || cfg_fixed)) |=> $stable(acc_q));

  // R11: at most +2 or -1 per cycle, so no wrap can occur
  p_acc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_x <= prev_x + 2) && (prev_x <= acc_x + 1));

  p_publish_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drift <= {{(GAIN_W-THR_W){1'b0}}, cfg_thresh}) |=> $stable(fgv_q));

  p_clamp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(clamp_up && clamp_dn));

  p_clamp_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && clamp_win && !vblank) |=> (!clamp_up && !clamp_dn));
endmodule

bind video_gain_loop vgl_checker #(
  .GAIN_W (GAIN_W),
  .ACC_W  (ACC_W),
  .THR_W  (THR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .clamp_win  (clamp_win),
  .vblank     (vblank),
  .cfg_hold   (cfg_hold),
  .cfg_fixed  (cfg_fixed),
  .cfg_thresh (cfg_thresh),
  .acc_q      (acc_q),
  .fgv_q      (fgv_q),
  .clamp_up   (clamp_up),
  .clamp_dn   (clamp_dn)
);

// File: tb/video_gain_loop_tb_top.sv
`timescale 1ns/1ps
module video_gain_loop_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic [8:0] s_sample = '0;
  logic       hsync_win = 1'b0, clamp_win = 1'b0, vblank = 1'b0;
  logic       cfg_hold = 1'b0, cfg_fixed = 1'b0, cfg_wp_off = 1'b0, cfg_chroma = 1'b0;
  logic [8:0] cfg_static_gain = '0;
  logic [2:0] cfg_thresh = '0;
  logic       s_ready, clamp_up, clamp_dn;
  logic [8:0] gain_code;
  logic       s_ready_s, clamp_up_s, clamp_dn_s;
  logic [8:0] gain_code_s;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  video_gain_loop dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .hsync_win(hsync_win), .clamp_win(clamp_win),
    .vblank(vblank), .cfg_hold(cfg_hold), .cfg_fixed(cfg_fixed),
    .cfg_static_gain(cfg_static_gain), .cfg_wp_off(cfg_wp_off),
    .cfg_thresh(cfg_thresh), .cfg_chroma(cfg_chroma),
    .gain_code(gain_code), .clamp_up(clamp_up), .clamp_dn(clamp_dn)
  );

  // narrow accumulator so both saturation ends are reachable
  video_gain_loop #(.ACC_W(10)) dut_s (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready_s),
    .s_sample(s_sample), .hsync_win(hsync_win), .clamp_win(clamp_win),
    .vblank(vblank), .cfg_hold(cfg_hold), .cfg_fixed(cfg_fixed),
    .cfg_static_gain(cfg_static_gain), .cfg_wp_off(cfg_wp_off),
    .cfg_thresh(cfg_thresh), .cfg_chroma(cfg_chroma),
    .gain_code(gain_code_s), .clamp_up(clamp_up_s), .clamp_dn(clamp_dn_s)
  );

  // fields: chroma, clamp_win, vblank, sample[8:0], exp_up, exp_dn
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 9'd100, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b0, 9'd120, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 9'd200, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b0, 9'd200, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b0, 9'd256, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 9'd300, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b0, 9'd50,  1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'd50,  1'b0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [8:0] smp,
                      input logic hs, input logic cw, input logic vb);
    s_valid = v; s_sample = smp; hsync_win = hs; clamp_win = cw; vblank = vb;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 9'd128, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    s_valid = 1'b0; hsync_win = 1'b0; clamp_win = 1'b0; vblank = 1'b0;
    cfg_hold = 1'b0; cfg_fixed = 1'b0; cfg_wp_off = 1'b0; cfg_chroma = 1'b0;
    cfg_thresh = 3'd0; cfg_static_gain = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic peaks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 9'd300, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic lines(input int n, input logic [8:0] tip);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 4; k++) step(1'b1, tip, 1'b1, 1'b0, 1'b0);
      step(1'b1, 9'd128, 1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 gain", gain_code, 256);
    check("R1 clamp_up", clamp_up, 0);
    check("R1 clamp_dn", clamp_dn, 0);
    check("R1 ready", s_ready, 1);

    // R2 clamp vector table
    for (int i = 0; i < NV; i++) begin
      cfg_chroma = VEC[i][13];
      step(1'b1, VEC[i][10:2], 1'b0, VEC[i][12], VEC[i][11]);
      check($sformatf("R2 vec%0d up", i), clamp_up, VEC[i][1]);
      check($sformatf("R2 vec%0d dn", i), clamp_dn, VEC[i][0]);
    end

    // R3 white peak half-rate decay
    do_reset();
    peaks(1024); idle();
    check("R3 peak decay", gain_code, 255);

    // R4 white peak disabled
    do_reset(); cfg_wp_off = 1'b1;
    peaks(1024); idle();
    check("R4 wp off", gain_code, 256);

    // R8 hold
    do_reset(); cfg_hold = 1'b1;
    peaks(1024); idle();
    check("R8 hold", gain_code, 256);

    // R8 vertical blanking
    do_reset();
    for (int i = 0; i < 1024; i++) step(1'b1, 9'd300, 1'b0, 1'b0, 1'b1);
    idle();
    check("R8 vblank", gain_code, 256);

    // R9 threshold 3
    do_reset(); cfg_thresh = 3'd3;
    peaks(3072); idle();
    check("R9 within thresh", gain_code, 256);
    peaks(1024); idle();
    check("R9 beyond thresh", gain_code, 252);

    // R6 per-line rise
    do_reset();
    lines(512, 9'd5); idle();
    check("R6 line rise", gain_code, 257);

    // R5 low sync tip
    do_reset();
    for (int i = 0; i < 1024; i++) step(1'b1, 9'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 9'd128, 1'b0, 1'b0, 1'b0);
    idle();
    check("R5 tip low", gain_code, 255);

    // R7 per-field rise after a white peak
    do_reset();
    step(1'b1, 9'd300, 1'b0, 1'b0, 1'b0);
    step(1'b1, 9'd128, 1'b0, 1'b0, 1'b0);
    lines(512, 9'd5); idle();
    check("R7 lines suppressed", gain_code, 256);
    do_reset();
    for (int f = 0; f < 512; f++) begin
      step(1'b1, 9'd300, 1'b0, 1'b0, 1'b0);
      lines(1, 9'd5);
      step(1'b1, 9'd128, 1'b0, 1'b0, 1'b1);
      step(1'b1, 9'd128, 1'b0, 1'b0, 1'b0);
    end
    idle();
    check("R7 field rise", gain_code, 257);

    // R10 fixed gain
    do_reset(); cfg_fixed = 1'b1; cfg_static_gain = 9'h1AB;
    idle();
    check("R10 static", gain_code, 'h1AB);
    peaks(1024); idle();
    check("R10 static held", gain_code, 'h1AB);
    cfg_fixed = 1'b0; idle();
    check("R10 acc held", gain_code, 256);

    // R11 saturation on narrow instance
    do_reset();
    peaks(1400); idle();
    check("R11 floor", gain_code_s, 0);
    step(1'b1, 9'd128, 1'b0, 1'b0, 1'b1);
    step(1'b1, 9'd128, 1'b0, 1'b0, 1'b0);
    lines(1100, 9'd5); idle();
    check("R11 ceiling", gain_code_s, 511);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule